// File: doc/BRIEF.md
# Hash-chained measurement register bank

The block keeps a set of 160-bit measurement registers. Software can never load them with a chosen value. The only way to change a register is to fold a new 160-bit measurement into it: the block hashes the register's present contents followed by the measurement with SHA-1 and writes the digest back. A register therefore records the whole ordered history of what was folded into it. Replaying the same measurements in the same order gives the same value. Any change in content or order gives a different value.

The registers fall into two classes. Low-numbered registers hold measurements taken from power-on. They return to their starting value only through the power-on reset input. The upper registers hold measurements of a later, dynamic launch and may be cleared by command, subject to the requester's locality. The launch registers within that group can be cleared only from the most privileged locality.

Requests arrive on a single command port. Each request carries an operation, a register index, a locality and a measurement. A done/error response follows. While the iterative hash engine is working, the port deasserts its ready signal.

Top module: `meas_bank`

## Requirements
- R1: The bank holds 24 registers of 160 bits each. A read (`cmd_op` = 2'b11) accepted in cycle 0 drives `rsp_done` high in cycle 1, with `rsp_err` low and the full register value on `rsp_data`.
- R2: After power-on reset, registers 17 to 22 hold all ones and every other register holds all zeros.
- R3: An extend (`cmd_op` = 2'b01) replaces the register with SHA-1 of the 320-bit message {old value, measurement}. The old value occupies the first (most significant) half. The message is padded to one 512-bit block with a 1 bit, zeros and a 64-bit length of 320. The response arrives in cycle 81 after acceptance and carries the new value on `rsp_data`.
- R4: Identical sequences of extends on two registers give identical values. The same two measurements applied in the opposite order give a different value.
- R5: Registers 0 to 15 cannot be cleared by command. A clear (`cmd_op` = 2'b10) to one of them returns `rsp_err` and leaves the value unchanged. Only power-on reset restores them.
- R6: While an extend is being hashed, `cmd_ready` is low from cycle 1 through the response cycle and is high again in the cycle after the response.
- R7: Registers 17 to 22 are cleared to all zeros only by a clear from locality 3. A clear from any other locality returns `rsp_err` and leaves the value unchanged.
- R8: Registers 16 and 23 are cleared to all zeros by a clear from any locality.
- R9: Any extend, clear or read with an index of 24 or above responds in cycle 1 with `rsp_err` high and `rsp_data` zero, and changes no register.
- R10: A request with `cmd_op` = 2'b00 produces no response and changes no register. No operation writes a supplied value into a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Request is taken on this edge when valid; low while hashing |
| cmd_op | input | 2 | 00 none, 01 extend, 10 clear, 11 read |
| cmd_idx | input | 5 | Register index |
| cmd_loc | input | 3 | Requester locality |
| cmd_meas | input | 160 | Measurement folded in by an extend |
| rsp_done | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Request refused, qualified by rsp_done |
| rsp_data | output | 160 | Read value or new value after an extend |

## Verification
The hardest situation to reach from the ports is showing that a refused request left a register untouched. The refusals are a clear of a static register, a clear of a launch register from the wrong locality, and an out-of-range index that could alias onto a low register. The stimulus first moves the target register away from its reset value with an extend, so that a wrongful clear would be visible. It then issues the refused request and reads the register back against a bench-side SHA-1 model. Order sensitivity is reached by feeding two registers the same pair of measurements in opposite orders after a fresh power-on reset.

// File: rtl/mb_pkg.sv
package mb_pkg;

    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_EXTEND = 2'b01,
        OP_CLEAR  = 2'b10,
        OP_READ   = 2'b11
    } mb_op_e;

    localparam int DIG_W  = 160;
    localparam int BLK_W  = 512;
    localparam int WORD_W = 32;
    localparam int N_WIN  = BLK_W / WORD_W;

    // chaining value that starts every one-block digest
    localparam logic [DIG_W-1:0] SHA_IV = {
        32'h67452301, 32'hEFCDAB89, 32'h98BADCFE, 32'h10325476, 32'hC3D2E1F0
    };

    localparam logic [31:0] K_CH  = 32'h5A827999;
    localparam logic [31:0] K_P1  = 32'h6ED9EBA1;
    localparam logic [31:0] K_MJ  = 32'h8F1BBCDC;
    localparam logic [31:0] K_P2  = 32'hCA62C1D6;

    function automatic logic [31:0] rotl(input logic [31:0] x, input int unsigned n);
        return (x << n) | (x >> (32 - n));
    endfunction

endpackage

// File: rtl/mb_sha1_iter.sv
module mb_sha1_iter
    import mb_pkg::*;
#(
    parameter int ROUNDS = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [BLK_W-1:0] block_i,
    output logic             done_o,
    output logic [DIG_W-1:0] digest_o
);
    localparam int RW = $clog2(ROUNDS);

    typedef struct packed {
        logic                          busy;
        logic [RW-1:0]                 rnd;
        logic [4:0][WORD_W-1:0]        v;
        logic [N_WIN-1:0][WORD_W-1:0]  win;
        logic                          done;
        logic [DIG_W-1:0]              dig;
    } core_t;

    core_t st_d, st_q;

    logic [WORD_W-1:0]      f_val, k_val, tmp, w_new;
    logic [4:0][WORD_W-1:0] v_nx;

    always_comb begin
        // round function and constant chosen by the round number
        if (32'(st_q.rnd) < 20) begin
            f_val = (st_q.v[3] & st_q.v[2]) | (~st_q.v[3] & st_q.v[1]);
            k_val = K_CH;
        end else if (32'(st_q.rnd) < 40) begin
            f_val = st_q.v[3] ^ st_q.v[2] ^ st_q.v[1];
            k_val = K_P1;
        end else if (32'(st_q.rnd) < 60) begin
            f_val = (st_q.v[3] & st_q.v[2]) | (st_q.v[3] & st_q.v[1]) | (st_q.v[2] & st_q.v[1]);
            k_val = K_MJ;
        end else begin
            f_val = st_q.v[3] ^ st_q.v[2] ^ st_q.v[1];
            k_val = K_P2;
        end
        // window head (index 15) holds the word for this round
        tmp   = rotl(st_q.v[4], 5) + f_val + st_q.v[0] + k_val + st_q.win[15];
        v_nx  = {tmp, st_q.v[4], rotl(st_q.v[3], 30), st_q.v[2], st_q.v[1]};
        w_new = rotl(st_q.win[2] ^ st_q.win[7] ^ st_q.win[13] ^ st_q.win[15], 1);

        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.busy = 1'b1;
            st_d.rnd  = '0;
            st_d.v    = SHA_IV;
            st_d.win  = block_i;
        end else if (st_q.busy) begin
            st_d.v   = v_nx;
            st_d.win = {st_q.win[N_WIN-2:0], w_new};
            st_d.rnd = st_q.rnd + 1'b1;
            if (st_q.rnd == RW'(ROUNDS - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                for (int i = 0; i < 5; i++) begin
                    st_d.dig[i*WORD_W +: WORD_W] = SHA_IV[i*WORD_W +: WORD_W] + v_nx[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o   = st_q.done;
    assign digest_o = st_q.dig;

endmodule

// File: rtl/mb_regs.sv
module mb_regs #(
    parameter int N_REGS    = 24,
    parameter int DW        = 160,
    parameter int LAUNCH_LO = 17,
    parameter int LAUNCH_HI = 22,
    localparam int IW       = $clog2(N_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_val,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_val
);
    logic [DW-1:0] regs_d [N_REGS];
    logic [DW-1:0] regs_q [N_REGS];

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < N_REGS; i++) begin
            regs_d[i] = regs_q[i];
            if (wr_en && wr_idx == IW'(i))  regs_d[i] = wr_val;
            if (clr_en && clr_idx == IW'(i)) regs_d[i] = '0;
            if (rd_idx == IW'(i))           rd_val    = regs_q[i];
        end
    end

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        localparam logic [DW-1:0] INIT =
            (g >= LAUNCH_LO && g <= LAUNCH_HI) ? {DW{1'b1}} : {DW{1'b0}};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[g] <= INIT;
            else        regs_q[g] <= regs_d[g];
        end
    end

endmodule

// File: rtl/meas_bank.sv
module meas_bank
    import mb_pkg::*;
#(
    parameter int N_REGS     = 24,
    parameter int LOC_W      = 3,
    parameter int STATIC_CNT = 16,
    parameter int LAUNCH_LO  = 17,
    parameter int LAUNCH_HI  = 22,
    parameter int PRIV_LOC   = 3,
    localparam int IW        = $clog2(N_REGS),
    localparam int DW        = DIG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [1:0]       cmd_op,
    input  logic [IW-1:0]    cmd_idx,
    input  logic [LOC_W-1:0] cmd_loc,
    input  logic [DW-1:0]    cmd_meas,
    output logic             rsp_done,
    output logic             rsp_err,
    output logic [DW-1:0]    rsp_data
);
    localparam int MSG_BITS = 2 * DW;
    localparam int ZPAD     = BLK_W - MSG_BITS - 1 - 64;

    typedef struct packed {
        logic          hashing;
        logic [IW-1:0] idx;
        logic          done;
        logic          err;
        logic [DW-1:0] data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             accept, idx_ok, clr_ok, in_launch;
    logic             sha_start, sha_done, clr_en;
    logic [DW-1:0]    rd_val, sha_dig;
    logic [BLK_W-1:0] block;

    assign cmd_ready = !ctl_q.hashing;
    assign accept    = cmd_valid && !ctl_q.hashing;
    assign idx_ok    = 32'(cmd_idx) < N_REGS;
    assign in_launch = 32'(cmd_idx) >= LAUNCH_LO && 32'(cmd_idx) <= LAUNCH_HI;
    assign clr_ok    = 32'(cmd_idx) >= STATIC_CNT &&
                       (!in_launch || 32'(cmd_loc) == PRIV_LOC);
    // old value first, then measurement, then padding and length
    assign block     = {rd_val, cmd_meas, 1'b1, {ZPAD{1'b0}}, 64'(MSG_BITS)};

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.err  = 1'b0;
        sha_start  = 1'b0;
        clr_en     = 1'b0;
        if (accept) begin
            case (mb_op_e'(cmd_op))
                OP_EXTEND: begin
                    if (idx_ok) begin
                        sha_start     = 1'b1;
                        ctl_d.hashing = 1'b1;
                        ctl_d.idx     = cmd_idx;
                    end else begin
                        ctl_d.done = 1'b1;
                        ctl_d.err  = 1'b1;
                        ctl_d.data = '0;
                    end
                end
                OP_CLEAR: begin
                    ctl_d.done = 1'b1;
                    ctl_d.data = '0;
                    if (idx_ok && clr_ok) clr_en    = 1'b1;
                    else                  ctl_d.err = 1'b1;
                end
                OP_READ: begin
                    ctl_d.done = 1'b1;
                    if (idx_ok) begin
                        ctl_d.data = rd_val;
                    end else begin
                        ctl_d.err  = 1'b1;
                        ctl_d.data = '0;
                    end
                end
                default: ;
            endcase
        end
        if (ctl_q.hashing && sha_done) ctl_d.hashing = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    mb_sha1_iter #(.ROUNDS(80)) u_sha (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (sha_start),
        .block_i  (block),
        .done_o   (sha_done),
        .digest_o (sha_dig)
    );

    mb_regs #(
        .N_REGS    (N_REGS),
        .DW        (DW),
        .LAUNCH_LO (LAUNCH_LO),
        .LAUNCH_HI (LAUNCH_HI)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sha_done),
        .wr_idx  (ctl_q.idx),
        .wr_val  (sha_dig),
        .clr_en  (clr_en),
        .clr_idx (cmd_idx),
        .rd_idx  (cmd_idx),
        .rd_val  (rd_val)
    );

    assign rsp_done = ctl_q.done | sha_done;
    assign rsp_err  = ctl_q.err;
    assign rsp_data = sha_done ? sha_dig : ctl_q.data;

endmodule

// File: rtl/meas_bank_chk.sv
module meas_bank_chk #(
    parameter int N_REGS     = 24,
    parameter int STATIC_CNT = 16,
    localparam int IW        = $clog2(N_REGS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [1:0]    cmd_op,
    input logic [IW-1:0] cmd_idx,
    input logic          rsp_done,
    input logic          rsp_err
);
    logic take;
    assign take = cmd_valid && cmd_ready;

    a_r6_busy_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == 2'b01 && 32'(cmd_idx) < N_REGS) |=> !cmd_ready);

    a_r6_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !cmd_ready) |=> cmd_ready);

    a_r1_read_responds: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == 2'b11) |=> rsp_done);

    a_r9_bad_index_err: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op != 2'b00 && 32'(cmd_idx) >= N_REGS) |=> (rsp_done && rsp_err));

    a_r5_static_clear_err: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == 2'b10 && 32'(cmd_idx) < STATIC_CNT) |=> (rsp_done && rsp_err));

    a_r9_err_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done);

    a_r10_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && !(cmd_valid && cmd_op != 2'b00)) |=> !rsp_done);

endmodule

bind meas_bank meas_bank_chk #(
    .N_REGS     (N_REGS),
    .STATIC_CNT (STATIC_CNT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_idx   (cmd_idx),
    .rsp_done  (rsp_done),
    .rsp_err   (rsp_err)
);

// File: tb/meas_bank_bench.sv
`timescale 1ns/1ps
module meas_bank_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [1:0]   cmd_op = 2'b00;
    logic [4:0]   cmd_idx = '0;
    logic [2:0]   cmd_loc = '0;
    logic [159:0] cmd_meas = '0;
    logic         rsp_done, rsp_err;
    logic [159:0] rsp_data;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    meas_bank u_meas_bank (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_loc(cmd_loc), .cmd_meas(cmd_meas),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_data(rsp_data)
    );

    // ---------------- reference model ----------------
    logic [159:0] model [24];

    function automatic logic [31:0] rol(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [159:0] ref_sha1(input logic [159:0] prev, input logic [159:0] m);
        logic [511:0] blk;
        logic [31:0]  w [80];
        logic [31:0]  h [5];
        logic [31:0]  a, b, c, d, e, f, k, t;
        blk = {prev, m, 1'b1, 127'd0, 64'd320};
        for (int i = 0; i < 16; i++) w[i] = blk[511 - 32*i -: 32];
        for (int i = 16; i < 80; i++) w[i] = rol(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
        h[0] = 32'h67452301; h[1] = 32'hEFCDAB89; h[2] = 32'h98BADCFE;
        h[3] = 32'h10325476; h[4] = 32'hC3D2E1F0;
        a = h[0]; b = h[1]; c = h[2]; d = h[3]; e = h[4];
        for (int i = 0; i < 80; i++) begin
            if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
            else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
            else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
            else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
            t = rol(a, 5) + f + e + k + w[i];
            e = d; d = c; c = rol(b, 30); b = a; a = t;
        end
        return {h[0] + a, h[1] + b, h[2] + c, h[3] + d, h[4] + e};
    endfunction

    function automatic logic [159:0] meas_of(input logic [7:0] seed);
        logic [31:0] x;
        x = 32'(seed) * 32'h9E3779B1 + 32'h00C0FFEE;
        return {x, ~x, x ^ 32'h5A5A5A5A, rol(x, 7), 32'(seed)};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 24; i++) model[i] = (i >= 17 && i <= 22) ? '1 : '0;
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // drive one request, wait for its response
    task automatic do_cmd(input logic [1:0] op, input logic [4:0] idx, input logic [2:0] loc,
                          input logic [159:0] meas, output logic err, output logic [159:0] data,
                          output int lat, output logic rdy1, output logic rdy_done,
                          output logic rdy_after);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_loc = loc; cmd_meas = meas;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
        lat = 1;
        rdy1 = cmd_ready;
        while (!rsp_done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        rdy_done = cmd_ready;
        err = rsp_err;
        data = rsp_data;
        @(negedge clk);
        rdy_after = cmd_ready;
    endtask

    task automatic read_chk(input logic [4:0] idx, input logic [159:0] exp, input string tag);
        logic e, r1, r2, r3; logic [159:0] d; int l;
        do_cmd(2'b11, idx, 3'd0, '0, e, d, l, r1, r2, r3);
        check(!e && d == exp && l == 1, tag, $sformatf("read reg %0d", idx), d, exp);
    endtask

    task automatic ext(input logic [4:0] idx, input logic [7:0] seed, input string tag);
        logic e, r1, r2, r3; logic [159:0] d; int l;
        model[idx] = ref_sha1(model[idx], meas_of(seed));
        do_cmd(2'b01, idx, 3'd0, meas_of(seed), e, d, l, r1, r2, r3);
        check(!e && d == model[idx] && l == 81, tag, $sformatf("extend reg %0d", idx), d, model[idx]);
    endtask

    task automatic power_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // ---------------- vector table ----------------
    typedef struct packed {
        logic [1:0] op;
        logic [4:0] idx;
        logic [2:0] loc;
        logic [7:0] seed;
        logic       err;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{2'b01, 5'd0,  3'd0, 8'd1, 1'b0, 8'd3},   // R3 extend static reg
        '{2'b01, 5'd0,  3'd2, 8'd2, 1'b0, 8'd3},   // R3 chained second extend
        '{2'b11, 5'd0,  3'd0, 8'd0, 1'b0, 8'd1},   // R1 read back
        '{2'b01, 5'd17, 3'd1, 8'd3, 1'b0, 8'd3},   // R3 extend from all-ones start
        '{2'b10, 5'd17, 3'd1, 8'd0, 1'b1, 8'd7},   // R7 wrong locality
        '{2'b11, 5'd17, 3'd1, 8'd0, 1'b0, 8'd7},   // R7 value kept
        '{2'b10, 5'd17, 3'd4, 8'd0, 1'b1, 8'd7},   // R7 locality above privileged
        '{2'b10, 5'd17, 3'd3, 8'd0, 1'b0, 8'd7},   // R7 privileged clear
        '{2'b11, 5'd17, 3'd0, 8'd0, 1'b0, 8'd7},   // R7 now zero
        '{2'b01, 5'd5,  3'd0, 8'd4, 1'b0, 8'd3},   // R3
        '{2'b10, 5'd5,  3'd3, 8'd0, 1'b1, 8'd5},   // R5 static clear refused
        '{2'b11, 5'd5,  3'd0, 8'd0, 1'b0, 8'd5},   // R5 value kept
        '{2'b01, 5'd16, 3'd0, 8'd5, 1'b0, 8'd3},   // R3
        '{2'b10, 5'd16, 3'd0, 8'd0, 1'b0, 8'd8},   // R8 clear from locality 0
        '{2'b11, 5'd16, 3'd0, 8'd0, 1'b0, 8'd8},   // R8 zero
        '{2'b01, 5'd23, 3'd4, 8'd6, 1'b0, 8'd3},   // R3
        '{2'b10, 5'd23, 3'd2, 8'd0, 1'b0, 8'd8},   // R8 clear from locality 2
        '{2'b01, 5'd24, 3'd0, 8'd7, 1'b1, 8'd9},   // R9 extend out of range
        '{2'b10, 5'd30, 3'd3, 8'd0, 1'b1, 8'd9},   // R9 clear out of range
        '{2'b11, 5'd31, 3'd0, 8'd0, 1'b1, 8'd9},   // R9 read out of range
        '{2'b11, 5'd22, 3'd0, 8'd0, 1'b0, 8'd2},   // R2 launch reg power-on ones
        '{2'b11, 5'd8,  3'd0, 8'd0, 1'b0, 8'd9}    // R9 possible alias target untouched
    };

    initial begin : watchdog
        #(100000 * 4);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic e, r1, r2, r3;
        logic [159:0] d, exp_d, v1, v2, v3;
        int l;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state after power-on
        read_chk(5'd0,  '0, "R2");
        read_chk(5'd17, '1, "R2");
        read_chk(5'd23, '0, "R2");
        check(cmd_ready == 1'b1, "R6", "ready idle after reset", 160'(cmd_ready), 160'd1);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            exp_d = '0;
            if (!v.err) begin
                case (v.op)
                    2'b01: begin model[v.idx] = ref_sha1(model[v.idx], meas_of(v.seed)); exp_d = model[v.idx]; end
                    2'b10: begin model[v.idx] = '0; exp_d = '0; end
                    2'b11: exp_d = model[v.idx];
                    default: ;
                endcase
            end
            do_cmd(v.op, v.idx, v.loc, meas_of(v.seed), e, d, l, r1, r2, r3);
            check(e == v.err, $sformatf("R%0d", v.req), $sformatf("vec %0d err", i), 160'(e), 160'(v.err));
            check(d == exp_d, $sformatf("R%0d", v.req), $sformatf("vec %0d data", i), d, exp_d);
            if (v.op == 2'b01 && !v.err) begin
                check(l == 81, "R3", $sformatf("vec %0d extend latency", i), 160'(l), 160'd81);
                check(!r1 && !r2 && r3, "R6", $sformatf("vec %0d ready busy/done/after", i),
                      160'({r1, r2, r3}), 160'(3'b001));
            end else begin
                check(l == 1, "R1", $sformatf("vec %0d latency", i), 160'(l), 160'd1);
            end
        end
        read_chk(5'd0, model[0], "R9");
        read_chk(5'd23, '0, "R8");

        // R10 op none gives no response and no change
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b00; cmd_idx = 5'd0; cmd_meas = '1;
        begin
            bit seen;
            seen = 1'b0;
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                if (rsp_done) seen = 1'b1;
            end
            cmd_valid = 1'b0;
            check(!seen, "R10", "no response to op none", 160'(seen), 160'd0);
        end
        read_chk(5'd0, model[0], "R10");

        // R6 a read held during hashing waits for the engine
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b01; cmd_idx = 5'd2; cmd_loc = 3'd0; cmd_meas = meas_of(8'd40);
        model[2] = ref_sha1(model[2], meas_of(8'd40));
        @(negedge clk);
        cmd_op = 2'b11;
        l = 0;
        while (!cmd_ready && l < 200) begin @(negedge clk); l++; end
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
        check(l == 81 && rsp_done && rsp_data == model[2], "R6", "held read sees new value",
              rsp_data, model[2]);

        // R5 and R2: power-on reset restores static and launch registers
        power_reset();
        read_chk(5'd0, '0, "R5");
        read_chk(5'd17, '1, "R2");

        // R4 order dependence
        ext(5'd1, 8'd10, "R4"); ext(5'd1, 8'd11, "R4");
        ext(5'd2, 8'd11, "R4"); ext(5'd2, 8'd10, "R4");
        ext(5'd3, 8'd10, "R4"); ext(5'd3, 8'd11, "R4");
        v1 = model[1]; v2 = model[2]; v3 = model[3];
        do_cmd(2'b11, 5'd1, 3'd0, '0, e, d, l, r1, r2, r3);
        check(d == v3, "R4", "same sequence same value", d, v3);
        do_cmd(2'b11, 5'd2, 3'd0, '0, e, d, l, r1, r2, r3);
        check(d == v2 && d != v1, "R4", "swapped order differs", d, v2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule